// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by reading two page table entries from memory, one at each level of a two-level table. A requester presents the virtual address, the kind of access (data read, data write or instruction fetch) and the current root table address. The walker then reads a top-level entry and, if that entry is valid, a leaf entry. It reports either a physical address or a fault with a cause code.

The top 10 bits of the virtual address select the top-level entry. The next 10 bits select the leaf entry. The low 12 bits pass through unchanged as the page offset. The walker checks the valid bit at both levels and checks the leaf's access rights against the access kind. It handles one request at a time.

The memory port is a read-only valid/ready request channel with a separate response strobe. The response may come back any number of cycles after the request is accepted.

Top module: `pt_walker`

## Requirements
- R1: The top-level entry is read from `root_base + vaddr[31:22]*4`. The leaf entry is read from `{top_frame, 12'h000} + vaddr[21:12]*4`. Both addresses appear on `mem_req_addr` in that order.
- R2: An entry is 32 bits wide. Bit 31 is the valid flag, bits 30:29 are the rights field, and bits 19:0 are a frame number. At the top level the frame number locates the leaf table; at the leaf level it is the physical page.
- R3: A top-level entry with bit 31 clear ends the walk with `done_fault`=1 and `done_cause`=0, and no leaf read is issued.
- R4: A leaf entry with bit 31 clear ends the walk with `done_fault`=1 and `done_cause`=1.
- R5: Access kinds are encoded 0 = read, 1 = write, 2 = fetch. Rights 00 allow read only, 01 allow read and write, 10 allow fetch only, and 11 allow nothing. A valid leaf whose rights do not allow the access gives `done_fault`=1 and `done_cause`=2.
- R6: A permitted walk gives `done_fault`=0, `done_cause`=0 and `done_paddr = {leaf_frame, vaddr[11:0]}`. A fault sets `done_paddr` to 0.
- R7: `done_valid` is high for exactly one cycle per walk. `done_paddr`, `done_fault` and `done_cause` hold their values until the next walk completes.
- R8: `req_ready` is high only while the walker is idle. `busy` is high from the cycle after acceptance through the `done_valid` cycle. A request is never accepted while `busy` is high.
- R9: `mem_req_valid` is raised only while busy. It stays high with a stable address until `mem_req_ready`. Exactly one request is issued per level, and a response of any latency is accepted.
- R10: During reset and immediately after it, `busy`, `done_valid` and `mem_req_valid` are 0 and `req_ready` is 1.
- R11: `root_base`, `req_vaddr` and `req_kind` are captured at acceptance. Changing them during a walk has no effect on its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| root_base | input | 32 | Byte address of the top-level table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Entry read data present |
| mem_rsp_data | input | 32 | Entry read data |
| busy | output | 1 | Walk in progress |
| done_valid | output | 1 | One-cycle completion strobe |
| done_fault | output | 1 | Walk ended in a fault |
| done_cause | output | 2 | Fault cause: 0 top-level invalid, 1 leaf invalid, 2 rights |
| done_paddr | output | 32 | Translated physical address |

## Verification
Two events can coincide here. A new request may be offered in the same cycle that the walker reports the previous result. In a second case, the caller changes the root address while a walk is still fetching entries. The bench holds `req_valid` high across the completion cycle and changes `root_base` straight after acceptance. It judges the outcome by the per-cycle rule that acceptance never coincides with `busy`, and by checking that the reported result matches the table reached through the root captured at acceptance. Memory ready and latency patterns vary from read to read, so each response lands in a different cycle relative to the request.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_L1,
    ST_WAIT_L1,
    ST_FETCH_L2,
    ST_WAIT_L2,
    ST_REPORT
  } walk_state_e;

  localparam logic [1:0] KIND_READ  = 2'd0;
  localparam logic [1:0] KIND_WRITE = 2'd1;
  localparam logic [1:0] KIND_FETCH = 2'd2;

  localparam logic [1:0] RIGHTS_RO = 2'd0;
  localparam logic [1:0] RIGHTS_RW = 2'd1;
  localparam logic [1:0] RIGHTS_EX = 2'd2;

  localparam logic [1:0] CAUSE_TOP_INVALID  = 2'd0;
  localparam logic [1:0] CAUSE_LEAF_INVALID = 2'd1;
  localparam logic [1:0] CAUSE_RIGHTS       = 2'd2;

endpackage

// File: rtl/pt_walker_entry_addr.sv
module pt_walker_entry_addr #(
  parameter int ADDR_W      = 32,
  parameter int IDX_W       = 10,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] table_base,
  input  logic [IDX_W-1:0]  index,
  output logic [ADDR_W-1:0] entry_addr
);
  logic [ADDR_W-1:0] offset;

  assign offset     = ADDR_W'(index) << ENTRY_SHIFT;
  assign entry_addr = table_base + offset;
endmodule

// File: rtl/pt_walker_perm.sv
module pt_walker_perm
  import pt_walker_pkg::*;
(
  input  logic [1:0] rights,
  input  logic [1:0] kind,
  output logic       permit
);
  always_comb begin
    unique case (rights)
      RIGHTS_RO: permit = (kind == KIND_READ);
      RIGHTS_RW: permit = (kind == KIND_READ) || (kind == KIND_WRITE);
      RIGHTS_EX: permit = (kind == KIND_FETCH);
      default:   permit = 1'b0;
    endcase
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int TOP_IDX_W  = 10,
  parameter int LEAF_IDX_W = 10,
  parameter int PTE_W      = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] root_base,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data,
  output logic              busy,
  output logic              done_valid,
  output logic              done_fault,
  output logic [1:0]        done_cause,
  output logic [ADDR_W-1:0] done_paddr
);
  localparam int OFF_W      = ADDR_W - TOP_IDX_W - LEAF_IDX_W;
  localparam int FRAME_W    = ADDR_W - OFF_W;
  localparam int VALID_BIT  = PTE_W - 1;
  localparam int RIGHTS_LSB = PTE_W - 3;
  localparam int LEVELS     = 2;
  localparam int MAX_IDX_W  = (TOP_IDX_W > LEAF_IDX_W) ? TOP_IDX_W : LEAF_IDX_W;

  walk_state_e state_q, state_d;

  logic [ADDR_W-1:0]  va_q;
  logic [1:0]         kind_q;
  logic [ADDR_W-1:0]  root_q;
  logic [FRAME_W-1:0] frame_q;
  logic [ADDR_W-1:0]  paddr_q, paddr_d;
  logic               fault_q, fault_d;
  logic [1:0]         cause_q, cause_d;

  logic accept;
  logic frame_en;
  logic result_en;

  logic [ADDR_W-1:0]    lvl_base [LEVELS];
  logic [MAX_IDX_W-1:0] lvl_idx  [LEVELS];
  logic [ADDR_W-1:0]    lvl_addr [LEVELS];

  logic               pte_valid;
  logic [1:0]         pte_rights;
  logic [FRAME_W-1:0] pte_frame;
  logic               permit;
  logic               unused_pte_bits;

  assign pte_valid       = mem_rsp_data[VALID_BIT];
  assign pte_rights      = mem_rsp_data[RIGHTS_LSB +: 2];
  assign pte_frame       = mem_rsp_data[FRAME_W-1:0];
  assign unused_pte_bits = ^mem_rsp_data[RIGHTS_LSB-1:FRAME_W];

  assign lvl_base[0] = root_q;
  assign lvl_idx[0]  = MAX_IDX_W'(va_q[ADDR_W-1 -: TOP_IDX_W]);
  assign lvl_base[1] = {frame_q, {OFF_W{1'b0}}};
  assign lvl_idx[1]  = MAX_IDX_W'(va_q[OFF_W +: LEAF_IDX_W]);

  for (genvar g = 0; g < LEVELS; g++) begin : g_level
    pt_walker_entry_addr #(
      .ADDR_W      (ADDR_W),
      .IDX_W       (MAX_IDX_W),
      .ENTRY_SHIFT ($clog2(PTE_W / 8))
    ) u_addr (
      .table_base (lvl_base[g]),
      .index      (lvl_idx[g]),
      .entry_addr (lvl_addr[g])
    );
  end

  pt_walker_perm u_perm (
    .rights (pte_rights),
    .kind   (kind_q),
    .permit (permit)
  );

  assign req_ready     = (state_q == ST_IDLE);
  assign busy          = (state_q != ST_IDLE);
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (state_q == ST_FETCH_L1) || (state_q == ST_FETCH_L2);
  assign mem_req_addr  = (state_q == ST_FETCH_L2) ? lvl_addr[1] : lvl_addr[0];
  assign done_valid    = (state_q == ST_REPORT);
  assign done_paddr    = paddr_q;
  assign done_fault    = fault_q;
  assign done_cause    = cause_q;

  always_comb begin
    state_d   = state_q;
    frame_en  = 1'b0;
    result_en = 1'b0;
    paddr_d   = '0;
    fault_d   = 1'b1;
    cause_d   = CAUSE_TOP_INVALID;
    unique case (state_q)
      ST_IDLE:     if (accept) state_d = ST_FETCH_L1;
      ST_FETCH_L1: if (mem_req_ready) state_d = ST_WAIT_L1;
      ST_WAIT_L1: begin
        if (mem_rsp_valid) begin
          if (pte_valid) begin
            frame_en = 1'b1;
            state_d  = ST_FETCH_L2;
          end else begin
            result_en = 1'b1;
            state_d   = ST_REPORT;
          end
        end
      end
      ST_FETCH_L2: if (mem_req_ready) state_d = ST_WAIT_L2;
      ST_WAIT_L2: begin
        if (mem_rsp_valid) begin
          result_en = 1'b1;
          state_d   = ST_REPORT;
          if (!pte_valid) begin
            cause_d = CAUSE_LEAF_INVALID;
          end else if (!permit) begin
            cause_d = CAUSE_RIGHTS;
          end else begin
            fault_d = 1'b0;
            paddr_d = {pte_frame, va_q[OFF_W-1:0]};
          end
        end
      end
      ST_REPORT:   state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      kind_q <= KIND_READ;
      root_q <= '0;
    end else if (accept) begin
      va_q   <= req_vaddr;
      kind_q <= req_kind;
      root_q <= root_base;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
    end else if (frame_en) begin
      frame_q <= pte_frame;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      paddr_q <= '0;
      fault_q <= 1'b0;
      cause_q <= CAUSE_TOP_INVALID;
    end else if (result_en) begin
      paddr_q <= paddr_d;
      fault_q <= fault_d;
      cause_q <= cause_d;
    end
  end
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              done_valid,
  input logic              done_fault,
  input logic [1:0]        done_cause,
  input logic [ADDR_W-1:0] done_paddr
);
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);

  p_done_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |-> busy);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  p_memreq_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid);

  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(done_paddr) && $stable(done_fault) && $stable(done_cause));

  p_cause_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> done_cause != 2'd3);

  p_fault_paddr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_fault |-> done_paddr == '0);
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .busy          (busy),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .done_valid    (done_valid),
  .done_fault    (done_fault),
  .done_cause    (done_cause),
  .done_paddr    (done_paddr)
);

// File: tb/pt_walker_tb_top.sv
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [31:0] req_vaddr;
  logic [1:0]  req_kind;
  logic [31:0] root_base;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        busy;
  logic        done_valid;
  logic        done_fault;
  logic [1:0]  done_cause;
  logic [31:0] done_paddr;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] rd_addrs [$];

  logic        pend;
  logic [1:0]  lat;
  logic [31:0] pend_addr;

  logic        prev_done;
  logic        hold_valid;
  logic [31:0] hold_paddr;
  logic        hold_fault;
  logic [1:0]  hold_cause;

  always #4 clk = ~clk;

  pt_walker dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vaddr     (req_vaddr),
    .req_kind      (req_kind),
    .root_base     (root_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .busy          (busy),
    .done_valid    (done_valid),
    .done_fault    (done_fault),
    .done_cause    (done_cause),
    .done_paddr    (done_paddr)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] va(input int t, input int l, input int o);
    return {t[9:0], l[9:0], o[11:0]};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // memory model: ready pattern and latency both vary with the cycle count
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_ready <= 1'b0;
      mem_rsp_valid <= 1'b0;
      mem_rsp_data  <= 32'h0;
      pend          <= 1'b0;
      lat           <= 2'd0;
      pend_addr     <= 32'h0;
    end else begin
      mem_req_ready <= ((cycles % 5) != 1);
      mem_rsp_valid <= 1'b0;
      if (mem_req_valid && mem_req_ready) begin
        rd_addrs.push_back(mem_req_addr);
        pend      <= 1'b1;
        lat       <= 2'(cycles % 4);
        pend_addr <= mem_req_addr;
      end else if (pend) begin
        if (lat == 2'd0) begin
          mem_rsp_valid <= 1'b1;
          mem_rsp_data  <= rd(pend_addr);
          pend          <= 1'b0;
        end else begin
          lat <= lat - 2'd1;
        end
      end
    end
  end

  // per-cycle comparison against the reference rules
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      check(req_ready == !busy, "R8", "ready vs busy", {31'd0, req_ready}, {31'd0, !busy});
      if (mem_req_valid)
        check(busy, "R9", "mem request while idle", {31'd0, busy}, 32'd1);
      if (prev_done)
        check(!done_valid, "R7", "done pulse width", {31'd0, done_valid}, 32'd0);
      if (hold_valid && !done_valid) begin
        check(done_paddr == hold_paddr, "R7", "paddr hold", done_paddr, hold_paddr);
        check(done_fault == hold_fault, "R7", "fault hold", {31'd0, done_fault}, {31'd0, hold_fault});
        check(done_cause == hold_cause, "R7", "cause hold", {30'd0, done_cause}, {30'd0, hold_cause});
      end
      prev_done = done_valid;
    end
  end

  task automatic walk(input string req, input logic [31:0] v, input logic [1:0] k,
                      input logic [31:0] base, input bit disturb, input bit linger);
    logic [31:0] e1, e2, a1, a2, exp_pa;
    logic        exp_f, perm;
    logic [1:0]  exp_c, rt;
    int          exp_n, n;
    a1 = base + {20'd0, v[31:22], 2'b00};
    e1 = rd(a1);
    a2 = {e1[19:0], 12'h000} + {20'd0, v[21:12], 2'b00};
    e2 = rd(a2);
    rt = e2[30:29];
    perm = (rt == 2'd0 && k == 2'd0) || (rt == 2'd1 && (k == 2'd0 || k == 2'd1)) ||
           (rt == 2'd2 && k == 2'd2);
    exp_pa = 32'h0; exp_f = 1'b1; exp_c = 2'd0; exp_n = 2;
    if (!e1[31]) exp_n = 1;
    else if (!e2[31]) exp_c = 2'd1;
    else if (!perm) exp_c = 2'd2;
    else begin exp_f = 1'b0; exp_pa = {e2[19:0], v[11:0]}; end

    while (!req_ready) @(negedge clk);
    rd_addrs.delete();
    req_valid = 1'b1; req_vaddr = v; req_kind = k; root_base = base;
    @(negedge clk);
    if (!linger) req_valid = 1'b0;
    if (disturb) begin root_base = ~base; req_vaddr = ~v; req_kind = 2'd3; end
    n = 0;
    while (!done_valid && n < 200) begin @(negedge clk); n++; end
    check(done_valid, req, "walk completion", {31'd0, done_valid}, 32'd1);
    check(done_fault == exp_f, req, "fault flag", {31'd0, done_fault}, {31'd0, exp_f});
    check(done_cause == exp_c, req, "cause", {30'd0, done_cause}, {30'd0, exp_c});
    check(done_paddr == exp_pa, req, "paddr", done_paddr, exp_pa);
    check(rd_addrs.size() == exp_n, req, "entry reads (R9)", rd_addrs.size(), exp_n);
    if (rd_addrs.size() > 0)
      check(rd_addrs[0] == a1, "R1", "top entry address", rd_addrs[0], a1);
    if (rd_addrs.size() > 1)
      check(rd_addrs[1] == a2, "R1", "leaf entry address", rd_addrs[1], a2);
    if (linger)
      check(busy && !req_ready, "R8", "no accept during report", {31'd0, req_ready}, 32'd0);
    hold_valid = 1'b1; hold_paddr = exp_pa; hold_fault = exp_f; hold_cause = exp_c;
    @(negedge clk);
    req_valid = 1'b0;
    if (linger) begin
      @(negedge clk);
      check(busy == 1'b0, "R8", "lingering request not double-walked", {31'd0, busy}, 32'd0);
    end
  endtask

  initial begin
    int wd;
    wd = 0;
    while (wd < 100000) begin @(negedge clk); wd++; end
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    prev_done = 1'b0; hold_valid = 1'b0;
    hold_paddr = 32'h0; hold_fault = 1'b0; hold_cause = 2'd0;
    req_valid = 1'b0; req_vaddr = 32'h0; req_kind = 2'd0; root_base = 32'h0;
    rst_n = 1'b0;
    // root A tables
    mem[32'h0001_0014] = 32'h8000_0020;            // top idx 5 -> leaf table 0x20000
    mem[32'h0001_001C] = 32'h0000_0030;            // top idx 7 invalid
    mem[32'h0001_0FFC] = 32'h8000_0040;            // top idx 1023 -> 0x40000
    mem[32'h0002_0004] = 32'h8001_2345;            // RO
    mem[32'h0002_0008] = 32'hA00A_BCDE;            // RW
    mem[32'h0002_000C] = 32'hC003_3333;            // EX
    mem[32'h0002_0010] = 32'h0005_5555;            // invalid leaf
    mem[32'h0002_0014] = 32'hE004_4444;            // rights 11
    mem[32'h0004_0FFC] = 32'hA00F_FFFF;            // RW at max index
    // root B tables
    mem[32'h0005_0014] = 32'h8000_0060;
    mem[32'h0006_0004] = 32'h8007_7777;
    repeat (3) @(negedge clk);
    check(req_ready && !busy && !done_valid && !mem_req_valid, "R10", "state in reset",
          {28'd0, req_ready, busy, done_valid, mem_req_valid}, 32'h8);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !busy && !done_valid && !mem_req_valid, "R10", "state after reset",
          {28'd0, req_ready, busy, done_valid, mem_req_valid}, 32'h8);

    walk("R6", va(5, 1, 12'h123), 2'd0, 32'h0001_0000, 0, 0);  // read on RO ok
    walk("R5", va(5, 1, 12'h123), 2'd1, 32'h0001_0000, 0, 0);  // write on RO
    walk("R6", va(5, 2, 12'hFED), 2'd1, 32'h0001_0000, 0, 0);  // write on RW
    walk("R5", va(5, 2, 12'h001), 2'd2, 32'h0001_0000, 0, 0);  // fetch on RW
    walk("R2", va(5, 3, 12'h7F0), 2'd2, 32'h0001_0000, 0, 0);  // fetch on EX
    walk("R5", va(5, 3, 12'h7F0), 2'd0, 32'h0001_0000, 0, 0);  // read on EX
    walk("R5", va(5, 5, 12'h010), 2'd0, 32'h0001_0000, 0, 0);  // rights 11
    walk("R4", va(5, 4, 12'h000), 2'd0, 32'h0001_0000, 0, 0);  // leaf invalid
    walk("R3", va(7, 1, 12'h444), 2'd0, 32'h0001_0000, 0, 0);  // top invalid
    walk("R1", va(1023, 1023, 12'hFFF), 2'd1, 32'h0001_0000, 0, 0);
    walk("R1", va(5, 1, 12'hABC), 2'd0, 32'h0005_0000, 0, 0);  // other root
    walk("R11", va(5, 1, 12'h055), 2'd0, 32'h0001_0000, 1, 0);
    walk("R8", va(5, 2, 12'h321), 2'd0, 32'h0001_0000, 0, 1);
    walk("R9", va(5, 3, 12'h999), 2'd2, 32'h0001_0000, 0, 0);
    repeat (4) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule